// File: doc/BRIEF.md
# Interrupt and Reset Input Conditioner

This block sits between a small processor core's asynchronous control pins and its sequencer. It takes four raw inputs: a level-sensitive maskable interrupt request, a non-maskable interrupt that reacts to a rising edge, a wait-test line and an external reset request. Each one passes through a multi-stage synchronizer, and the block turns the results into clean flags that the sequencer can use at instruction boundaries.

The sequencer gives the block two things. A strobe marks the last clock of each instruction, and an acknowledge pulse marks that a non-maskable interrupt has been taken. At each boundary the block reports which service, if any, the core should enter next. The non-maskable request always wins, and it carries a fixed vector type. The block also gives a ready signal for the wait instruction. It produces a qualified core reset that is only honoured after the request has stayed high for a minimum number of cycles.

Top module: `ifr_front`

## Requirements
- R1: Every raw input (irq_i, nmi_i, test_i, reset_req_i) passes through SYNC_STAGES flip-flops before it affects any output. With the default of 2, a change driven before clock edge E first shows at test_ready_o after edge E+1, and never after edge E.
- R2: The maskable request is sampled only on a clock edge where instr_last_i is 1. On that edge intr_pend_o loads (synchronized irq_i AND ie_i) and holds that value until the next boundary. If no NMI is pending, take_intr_o pulses high for exactly the one cycle after that edge.
- R3: While ie_i is 0, a high maskable request has no effect: at a boundary intr_pend_o loads 0 and take_intr_o stays 0.
- R4: A low-to-high transition of the synchronized nmi_i sets nmi_pend_o one edge after the synchronizer output rises. A level that is held high does not set the flag again after it has been cleared.
- R5: nmi_pend_o stays set until the sequencer pulses nmi_ack_i or an accepted reset occurs. The flag clears on the edge that samples the acknowledge.
- R6: At a boundary with nmi_pend_o set, take_nmi_o pulses for one cycle and vec_o shows NMI_TYPE (default 2); vec_o is 0 otherwise. take_intr_o stays 0 in that cycle even if the maskable request qualifies.
- R7: test_ready_o is the inverse of the synchronized test_i: it is 1 (continue) when test_i is low and 0 (stay idle) when test_i is high. It is 1 after the power-on reset.
- R8: core_reset_o rises only after the synchronized reset request has been sampled high on MIN_RST_CYCLES consecutive edges (default 4). With default parameters it is high after the sixth edge following the raw rise. A shorter request is discarded, and then no output changes.
- R9: core_reset_o stays high while the synchronized request is high. It falls on the edge after the synchronized request goes low, which is the third edge after the raw fall.
- R10: While core_reset_o is high, nmi_pend_o, intr_pend_o, take_nmi_o and take_intr_o are cleared on every edge. NMI edges and boundaries seen during that time are dropped.
- R11: take_nmi_o and take_intr_o are never high together, and each one follows an edge at which instr_last_i was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| irq_i | input | 1 | Raw maskable interrupt request, active high level |
| nmi_i | input | 1 | Raw non-maskable interrupt, rising edge |
| test_i | input | 1 | Raw wait-test line, low means continue |
| reset_req_i | input | 1 | Raw external reset request, active high |
| ie_i | input | 1 | Interrupt-enable bit from the core |
| instr_last_i | input | 1 | Last clock of the current instruction |
| nmi_ack_i | input | 1 | Sequencer has taken the pending NMI |
| nmi_pend_o | output | 1 | Sticky non-maskable request pending |
| intr_pend_o | output | 1 | Maskable request latched at the last boundary |
| take_nmi_o | output | 1 | One-cycle pulse: enter NMI service |
| take_intr_o | output | 1 | One-cycle pulse: enter maskable service |
| vec_o | output | VEC_W | Vector type while take_nmi_o is high, else 0 |
| test_ready_o | output | 1 | Wait instruction may continue |
| core_reset_o | output | 1 | Qualified reset for the core |

## Verification
The bench builds the block with its defaults: two synchronizer stages, a four-cycle minimum for reset and vector type 2. With these values every latency is a small fixed count of edges. The bench can therefore test exact edges: the one-edge-early sample on the wait-test path, a reset of three cycles against one of four, and the third-edge release. It also drives an NMI edge that is held across an acknowledge, a boundary where both requests are pending, and a reset that clears flags which are already set.

// File: rtl/ifr_pkg.sv
// Package: shared constants and helpers for the interrupt/reset front end.
// Assumes: all users compile this first.
package ifr_pkg;
    localparam int unsigned IFR_SYNC_DEF    = 2;
    localparam int unsigned IFR_MIN_RST_DEF = 4;
    localparam int unsigned IFR_VEC_W_DEF   = 8;
    localparam int unsigned IFR_NMI_TYPE    = 2;

    // Raw-input lane order inside the shared synchronizer bank.
    typedef enum int unsigned {
        LANE_IRQ  = 0,
        LANE_NMI  = 1,
        LANE_TEST = 2,
        LANE_RST  = 3,
        LANE_NUM  = 4
    } ifr_lane_e;

    // Width needed to count from 0 to n inclusive.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/ifr_sync.sv
// Module: a bank of WIDTH independent synchronizer chains, each STAGES deep.
// Assumes: each bit is independent (no bus coherency is required); the
// stages clear to 0 under the synchronous active-low reset.
module ifr_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw inputs into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= '0;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_next
                // Shift each further stage from the one before it.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ifr_rst_qual.sv
// Module: qualifies the synchronized reset request. It asserts the core
// reset only after MIN_CYCLES consecutive high samples and releases it on
// the first low sample.
// Assumes: req_s is already synchronous to clk.
module ifr_rst_qual
    import ifr_pkg::*;
#(
    parameter int unsigned MIN_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    output logic core_reset_o
);
    localparam int unsigned CW = cnt_width(MIN_CYCLES);
    localparam logic [CW-1:0] CNT_LAST = CW'(MIN_CYCLES - 1);
    localparam logic [CW-1:0] CNT_SAT  = CW'(MIN_CYCLES);

    logic [CW-1:0] run_q;
    logic          hold_q;

    // Count consecutive high samples and raise the reset at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_s) begin
            run_q  <= '0;
            hold_q <= 1'b0;
        end else if (run_q != CNT_SAT) begin
            run_q <= run_q + 1'b1;
            if (run_q == CNT_LAST) hold_q <= 1'b1;
        end
    end

    assign core_reset_o = hold_q;
endmodule

// File: rtl/ifr_nmi_edge.sv
// Module: detects rising edges of the synchronized NMI and keeps a
// sticky pending flag. The sequencer acknowledge or an accepted reset
// clears the flag; a new edge in the same cycle as an acknowledge wins.
// Assumes: nmi_s is synchronous.
module ifr_nmi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_s,
    input  logic ack_i,
    input  logic clr_i,
    output logic pend_o
);
    logic prev_q;
    logic pend_q;
    logic rise;

    // Find a low-to-high step between two consecutive samples.
    always_comb rise = nmi_s & ~prev_q;

    // Record the previous sample for the edge compare.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= nmi_s;
    end

    // Keep the pending flag until acknowledge or an accepted reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) pend_q <= 1'b0;
        else if (rise)       pend_q <= 1'b1;
        else if (ack_i)      pend_q <= 1'b0;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/ifr_boundary.sv
// Module: samples the maskable level at instruction boundaries and
// decides which service to enter. NMI has priority; the vector type
// shows only while the NMI take pulse is high.
// Assumes: boundary_i is high during exactly the last clock of an
// instruction.
module ifr_boundary #(
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned NMI_TYPE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary_i,
    input  logic             irq_s,
    input  logic             ie_i,
    input  logic             nmi_pend_i,
    input  logic             clr_i,
    output logic             intr_pend_o,
    output logic             take_nmi_o,
    output logic             take_intr_o,
    output logic [VEC_W-1:0] vec_o
);
    localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(NMI_TYPE);

    logic qualified;

    // The maskable request counts only while the core enables it.
    always_comb qualified = irq_s & ie_i;

    // Latch the qualified level at each boundary and hold it between boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)  intr_pend_o <= 1'b0;
        else if (boundary_i)  intr_pend_o <= qualified;
    end

    // Issue one-cycle take pulses with NMI ahead of the maskable request.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || !boundary_i) begin
            take_nmi_o  <= 1'b0;
            take_intr_o <= 1'b0;
            vec_o       <= '0;
        end else begin
            take_nmi_o  <= nmi_pend_i;
            take_intr_o <= ~nmi_pend_i & qualified;
            vec_o       <= nmi_pend_i ? NMI_VEC : '0;
        end
    end
endmodule

// File: rtl/ifr_front.sv
// Module: top of the interrupt and reset input conditioner. It synchronizes
// the four raw pins, qualifies reset, tracks NMI and samples the maskable
// request at boundaries.
// Assumes: ie_i, instr_last_i and nmi_ack_i come from synchronous core
// logic.
module ifr_front
    import ifr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES    = IFR_SYNC_DEF,
    parameter int unsigned MIN_RST_CYCLES = IFR_MIN_RST_DEF,
    parameter int unsigned VEC_W          = IFR_VEC_W_DEF,
    parameter int unsigned NMI_TYPE       = IFR_NMI_TYPE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_i,
    input  logic             nmi_i,
    input  logic             test_i,
    input  logic             reset_req_i,
    input  logic             ie_i,
    input  logic             instr_last_i,
    input  logic             nmi_ack_i,
    output logic             nmi_pend_o,
    output logic             intr_pend_o,
    output logic             take_nmi_o,
    output logic             take_intr_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             test_ready_o,
    output logic             core_reset_o
);
    localparam int unsigned LANES = LANE_NUM;

    logic [LANES-1:0] raw_bus;
    logic [LANES-1:0] sync_bus;
    logic             irq_sync;
    logic             nmi_sync;
    logic             test_sync;
    logic             rst_sync;

    // Collect the raw pins into the synchronizer lanes.
    always_comb begin
        raw_bus            = '0;
        raw_bus[LANE_IRQ]  = irq_i;
        raw_bus[LANE_NMI]  = nmi_i;
        raw_bus[LANE_TEST] = test_i;
        raw_bus[LANE_RST]  = reset_req_i;
    end

    ifr_sync #(.WIDTH(LANES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_bus),
        .sync_o  (sync_bus)
    );

    // Split the synchronized lanes back into named signals.
    always_comb begin
        irq_sync  = sync_bus[LANE_IRQ];
        nmi_sync  = sync_bus[LANE_NMI];
        test_sync = sync_bus[LANE_TEST];
        rst_sync  = sync_bus[LANE_RST];
    end

    ifr_rst_qual #(.MIN_CYCLES(MIN_RST_CYCLES)) u_rst (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_s        (rst_sync),
        .core_reset_o (core_reset_o)
    );

    ifr_nmi_edge u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .nmi_s  (nmi_sync),
        .ack_i  (nmi_ack_i),
        .clr_i  (core_reset_o),
        .pend_o (nmi_pend_o)
    );

    ifr_boundary #(.VEC_W(VEC_W), .NMI_TYPE(NMI_TYPE)) u_bnd (
        .clk         (clk),
        .rst_n       (rst_n),
        .boundary_i  (instr_last_i),
        .irq_s       (irq_sync),
        .ie_i        (ie_i),
        .nmi_pend_i  (nmi_pend_o),
        .clr_i       (core_reset_o),
        .intr_pend_o (intr_pend_o),
        .take_nmi_o  (take_nmi_o),
        .take_intr_o (take_intr_o),
        .vec_o       (vec_o)
    );

    // The wait instruction may proceed while the synchronized test line is low.
    always_comb test_ready_o = ~test_sync;
endmodule

// File: rtl/ifr_front_chk.sv
// Module: property checker for ifr_front, attached with bind.
// Assumes: it sees the synchronized reset request of the top.
module ifr_front_chk #(
    parameter int unsigned MIN_RST_CYCLES = 4
) (
    input logic clk,
    input logic rst_n,
    input logic ie_i,
    input logic instr_last_i,
    input logic nmi_ack_i,
    input logic rst_sync,
    input logic nmi_pend_o,
    input logic intr_pend_o,
    input logic take_nmi_o,
    input logic take_intr_o,
    input logic core_reset_o
);
    localparam int unsigned CW = ifr_pkg::cnt_width(MIN_RST_CYCLES);
    localparam logic [CW-1:0] SAT = CW'(MIN_RST_CYCLES);

    logic [CW-1:0] seen_q;

    // Count consecutive high samples of the synchronized reset request.
    always_ff @(posedge clk) begin
        if (!rst_n || !rst_sync) seen_q <= '0;
        else if (seen_q != SAT)  seen_q <= seen_q + 1'b1;
    end

    p_boundary_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_intr_o || take_nmi_o) |-> $past(instr_last_i));

    p_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_intr_o |-> $past(ie_i));

    p_nmi_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend_o && !nmi_ack_i && !core_reset_o) |=> nmi_pend_o);

    p_take_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_nmi_o, take_intr_o}));

    p_rst_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_reset_o) |-> (seen_q >= SAT));

    p_rst_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        core_reset_o |=> (!nmi_pend_o && !intr_pend_o && !take_nmi_o && !take_intr_o));
endmodule

bind ifr_front ifr_front_chk #(.MIN_RST_CYCLES(MIN_RST_CYCLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ie_i         (ie_i),
    .instr_last_i (instr_last_i),
    .nmi_ack_i    (nmi_ack_i),
    .rst_sync     (rst_sync),
    .nmi_pend_o   (nmi_pend_o),
    .intr_pend_o  (intr_pend_o),
    .take_nmi_o   (take_nmi_o),
    .take_intr_o  (take_intr_o),
    .core_reset_o (core_reset_o)
);

// File: tb/sim_ifr_front.sv
// Bench: scoreboard of expected output values, checked just after each falling edge.
module sim_ifr_front;
    localparam int SEL_NPEND = 0, SEL_IPEND = 1, SEL_TNMI = 2, SEL_TINT = 3,
                   SEL_TRDY = 4, SEL_CRST = 5, SEL_VEC = 6;

    typedef struct {
        int    sel;
        int    expv;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_i = 0, nmi_i = 0, test_i = 0, reset_req_i = 0;
    logic ie_i = 0, instr_last_i = 0, nmi_ack_i = 0;
    logic nmi_pend_o, intr_pend_o, take_nmi_o, take_intr_o, test_ready_o, core_reset_o;
    logic [7:0] vec_o;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    always #10 clk = ~clk;

    ifr_front u0 (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .nmi_i(nmi_i), .test_i(test_i),
        .reset_req_i(reset_req_i), .ie_i(ie_i), .instr_last_i(instr_last_i),
        .nmi_ack_i(nmi_ack_i), .nmi_pend_o(nmi_pend_o), .intr_pend_o(intr_pend_o),
        .take_nmi_o(take_nmi_o), .take_intr_o(take_intr_o), .vec_o(vec_o),
        .test_ready_o(test_ready_o), .core_reset_o(core_reset_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_now(input int sel, input int expv, input string req);
        exp_t e;
        e.sel = sel; e.expv = expv; e.req = req;
        exp_q.push_back(e);
    endtask

    function automatic int pick(input int sel);
        case (sel)
            SEL_NPEND: return int'(nmi_pend_o);
            SEL_IPEND: return int'(intr_pend_o);
            SEL_TNMI:  return int'(take_nmi_o);
            SEL_TINT:  return int'(take_intr_o);
            SEL_TRDY:  return int'(test_ready_o);
            SEL_CRST:  return int'(core_reset_o);
            default:   return int'(vec_o);
        endcase
    endfunction

    // Monitor: compare the queued expectations just after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t e;
                int   act;
                e = exp_q.pop_front();
                act = pick(e.sel);
                n_checks++;
                if (act != e.expv) begin
                    n_fail++;
                    $display("FAIL %s sel=%0d actual=%0d expected=%0d", e.req, e.sel, act, e.expv);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Driver.
    initial begin
        tick(3);
        rst_n = 1'b1;
        // Reset state (R7: test_ready 1 after power-on reset).
        expect_now(SEL_NPEND, 0, "R5"); expect_now(SEL_IPEND, 0, "R2");
        expect_now(SEL_TNMI, 0, "R11"); expect_now(SEL_TINT, 0, "R11");
        expect_now(SEL_CRST, 0, "R8");  expect_now(SEL_TRDY, 1, "R7");
        tick(1);

        // R1 / R7: test path latency of two edges.
        test_i = 1;
        tick(1); expect_now(SEL_TRDY, 1, "R1");
        tick(1); expect_now(SEL_TRDY, 0, "R7");
        test_i = 0;
        tick(2); expect_now(SEL_TRDY, 1, "R7");

        // R2: level is sampled only at a boundary.
        ie_i = 1; irq_i = 1;
        tick(4); expect_now(SEL_IPEND, 0, "R2");
        instr_last_i = 1; tick(1); instr_last_i = 0;
        expect_now(SEL_TINT, 1, "R2"); expect_now(SEL_IPEND, 1, "R2");
        expect_now(SEL_TNMI, 0, "R11");
        tick(1); expect_now(SEL_TINT, 0, "R2"); expect_now(SEL_IPEND, 1, "R2");

        // R3: masked request is ignored.
        ie_i = 0;
        tick(1);
        instr_last_i = 1; tick(1); instr_last_i = 0;
        expect_now(SEL_TINT, 0, "R3"); expect_now(SEL_IPEND, 0, "R3");

        // R2: low level at a boundary with enable set.
        ie_i = 1; irq_i = 0;
        tick(3);
        instr_last_i = 1; tick(1); instr_last_i = 0;
        expect_now(SEL_TINT, 0, "R2"); expect_now(SEL_IPEND, 0, "R2");

        // R4 / R5: edge sets sticky flag, ack clears, held level does not retrigger.
        nmi_i = 1;
        tick(2); expect_now(SEL_NPEND, 0, "R4");
        tick(1); expect_now(SEL_NPEND, 1, "R4");
        tick(5); expect_now(SEL_NPEND, 1, "R5");
        nmi_ack_i = 1; tick(1); nmi_ack_i = 0;
        expect_now(SEL_NPEND, 0, "R5");
        tick(3); expect_now(SEL_NPEND, 0, "R4");

        // R6: NMI wins over a qualified maskable request, vector type 2.
        nmi_i = 0; tick(3);
        nmi_i = 1; irq_i = 1; ie_i = 1;
        tick(4); expect_now(SEL_NPEND, 1, "R4");
        instr_last_i = 1; tick(1); instr_last_i = 0;
        expect_now(SEL_TNMI, 1, "R6"); expect_now(SEL_VEC, 2, "R6");
        expect_now(SEL_TINT, 0, "R6"); expect_now(SEL_IPEND, 1, "R2");
        tick(1); expect_now(SEL_VEC, 0, "R6"); expect_now(SEL_TNMI, 0, "R6");
        nmi_ack_i = 1; tick(1); nmi_ack_i = 0;
        expect_now(SEL_NPEND, 0, "R5");
        nmi_i = 0; tick(3);

        // Set NMI pending again before the reset tests.
        nmi_i = 1; tick(3); expect_now(SEL_NPEND, 1, "R4");

        // R8: a three-cycle reset request is discarded.
        reset_req_i = 1; tick(3); reset_req_i = 0;
        for (int k = 0; k < 6; k++) begin
            expect_now(SEL_CRST, 0, "R8");
            tick(1);
        end
        expect_now(SEL_NPEND, 1, "R8"); expect_now(SEL_IPEND, 1, "R8");

        // R8 / R10 / R9: a long request is accepted, clears flags, then releases.
        reset_req_i = 1;
        tick(5); expect_now(SEL_CRST, 0, "R8");
        tick(1); expect_now(SEL_CRST, 1, "R8");
        tick(1); expect_now(SEL_NPEND, 0, "R10"); expect_now(SEL_IPEND, 0, "R10");
        instr_last_i = 1; tick(1); instr_last_i = 0;
        expect_now(SEL_TNMI, 0, "R10"); expect_now(SEL_TINT, 0, "R10");
        reset_req_i = 0;
        tick(2); expect_now(SEL_CRST, 1, "R9");
        tick(1); expect_now(SEL_CRST, 0, "R9");
        tick(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule